// File: doc/BRIEF.md
# Field-Interleaving Frame Store Writer

This block runs in the memory clock domain between a capture FIFO and a single-port memory controller. It drains pixel words from the capture FIFO. Each word carries a start-of-line tag and a field bit. For each word it issues one memory write. The write address places the lines of the first field on even rows and the lines of the second field on odd rows, so that two interlaced fields build one progressive frame in the buffer.

Once a whole frame has been written, a second, linear address counter reads the buffer back in display order, one word per request. Each returned word goes to a display FIFO. Reads are only issued while that FIFO reports room. Only one request is outstanding at a time. When a pending capture word and a possible read meet, the write goes first, so the capture side never backs up behind display traffic.

The capture FIFO presents its head word while it is not empty, and a one-cycle read strobe removes that word. A memory request holds its strobe, address and data steady until the controller returns a one-cycle done pulse. On a read, the returned data is valid during that done cycle.

Top module: `fieldWeaver`

## Requirements
- R1: While reset is held and in the first cycle after it, capRd, memWr, memRd and dispWr are low and frameDone is low.
- R2: capRd is high for exactly one cycle per taken word. It is high only while capEmpty is low and no memory request is active. Each taken word yields exactly one memory write.
- R3: The write address is (2*line+field)*LINE_WORDS + column. Here field is capField (0 = first field, 1 = second field). column is 0 on a word with capSol=1 and otherwise one more than the previous word's column. line is 0 on the first start-of-line word after a change of capField, and otherwise one more than the previous line on each start-of-line word.
- R4: Once memWr or memRd rises, that strobe, memAddr and memWrData stay unchanged until the cycle in which memDone is high. The strobe is low in the cycle after it.
- R5: frameDone rises in the cycle after memDone completes a write with field 1, line LINES_PER_FIELD-1 and column LINE_WORDS-1. It then stays high until reset.
- R6: No read is issued while frameDone is low. No read is started while dispAlmostFull is high.
- R7: Read addresses run 0, 1, ..., FRAME_WORDS-1 and then wrap to 0.
- R8: dispWr is high exactly in the cycle in which memDone completes a read, with dispData equal to memRdData.
- R9: When capEmpty is low while the block is idle, the next request is a write, even if a read is also allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| capEmpty | input | 1 | Capture FIFO has no word |
| capData | input | DATA_W | Head word pixel data |
| capSol | input | 1 | Head word is first of a line |
| capField | input | 1 | Head word field bit |
| capRd | output | 1 | Remove head word from capture FIFO |
| memAddr | output | ADDR_W | Request word address |
| memWrData | output | DATA_W | Write data |
| memWr | output | 1 | Write request, held until done |
| memRd | output | 1 | Read request, held until done |
| memDone | input | 1 | Request complete (one cycle) |
| memRdData | input | DATA_W | Read data, valid with memDone |
| dispAlmostFull | input | 1 | Display FIFO nearly full |
| dispWr | output | 1 | Push to display FIFO |
| dispData | output | DATA_W | Word pushed to display FIFO |
| frameDone | output | 1 | A full woven frame has been stored |

## Verification
The write path and the read path can both want the memory port in the same idle cycle. The bench provokes this after a frame is stored. While dispAlmostFull holds reads back, it presents a new capture word and releases dispAlmostFull at the same falling edge. It then judges the kind of the next request seen at the memory port, and the buffer word that the write changes. Variable memory latency (zero to two cycles) runs through a full two-field capture, an exhaustive check of every buffer word, and a read stream longer than one frame to cover the wrap.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POP  = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } fwState_t;

  typedef struct packed {
    logic pop;
    logic rdSel;
    logic wrDone;
    logic rdDone;
  } fwStrobe_t;

endpackage

// File: rtl/weaverCtl.sv
module weaverCtl
  import fw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      capEmpty,
  input  logic      dispAlmostFull,
  input  logic      frameDone,
  input  logic      memDone,
  output logic      capRd,
  output logic      memWr,
  output logic      memRd,
  output fwStrobe_t stb
);

  fwState_t state, stateNext;
  logic     isRead, isReadNext;
  logic     active;

  always_comb begin
    stateNext  = state;
    isReadNext = isRead;
    unique case (state)
      ST_IDLE: begin
        if (!capEmpty) begin
          stateNext  = ST_POP;
          isReadNext = 1'b0;
        end else if (frameDone && !dispAlmostFull) begin
          stateNext  = ST_REQ;
          isReadNext = 1'b1;
        end
      end
      ST_POP:  stateNext = ST_REQ;
      ST_REQ:  stateNext = memDone ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (memDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state  <= stateNext;
      isRead <= isReadNext;
    end
  end

  assign active     = (state == ST_REQ) || (state == ST_WAIT);
  assign capRd      = (state == ST_POP);
  assign memWr      = active && !isRead;
  assign memRd      = active && isRead;
  assign stb.pop    = capRd;
  assign stb.rdSel  = isRead;
  assign stb.wrDone = memWr && memDone;
  assign stb.rdDone = memRd && memDone;

  // R2
  pop_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    capRd |-> !memWr && !memRd && !$past(capRd));

  // R9
  write_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !capEmpty) |=> capRd);

  // R6
  read_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |-> frameDone && !$past(dispAlmostFull));

  // R4
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memWr || memRd) && !memDone) |=> (memWr == $past(memWr)) && (memRd == $past(memRd)) && (memWr || memRd));

  // R4
  drop_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memWr || memRd) && memDone) |=> !memWr && !memRd);

endmodule

// File: rtl/weaverDp.sv
module weaverDp
  import fw_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int LINE_WORDS      = 8,
  parameter int LINES_PER_FIELD = 4,
  parameter int ADDR_W          = $clog2(2 * LINES_PER_FIELD * LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwStrobe_t         stb,
  input  logic [DATA_W-1:0] capData,
  input  logic              capSol,
  input  logic              capField,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              dispWr,
  output logic [DATA_W-1:0] dispData,
  output logic              frameDone
);

  localparam int FRAME_WORDS = 2 * LINES_PER_FIELD * LINE_WORDS;
  localparam int COL_W       = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int LINE_W      = (LINES_PER_FIELD > 1) ? $clog2(LINES_PER_FIELD) : 1;

  logic [COL_W-1:0]  colCnt;
  logic [LINE_W-1:0] lineCnt;
  logic              curField, haveField;
  logic [DATA_W-1:0] wordReg;
  logic [ADDR_W-1:0] rdPtr, wrAddr;
  logic [LINE_W:0]   rowIdx;
  logic              lastWord;

  // Capture word and advance line/column position on each pop.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt    <= '0;
      lineCnt   <= '0;
      curField  <= 1'b0;
      haveField <= 1'b0;
      wordReg   <= '0;
    end else if (stb.pop) begin
      wordReg <= capData;
      if (capSol) begin
        colCnt    <= '0;
        curField  <= capField;
        haveField <= 1'b1;
        if (!haveField || capField != curField) lineCnt <= '0;
        else                                    lineCnt <= lineCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  assign rowIdx   = {lineCnt, curField};
  assign wrAddr   = ADDR_W'(rowIdx) * ADDR_W'(LINE_WORDS) + ADDR_W'(colCnt);
  assign lastWord = curField && (lineCnt == LINE_W'(LINES_PER_FIELD - 1))
                    && (colCnt == COL_W'(LINE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN)                         frameDone <= 1'b0;
    else if (stb.wrDone && lastWord)   frameDone <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdPtr <= '0;
    else if (stb.rdDone)
      rdPtr <= (rdPtr == ADDR_W'(FRAME_WORDS - 1)) ? '0 : rdPtr + 1'b1;
  end

  assign memAddr   = stb.rdSel ? rdPtr : wrAddr;
  assign memWrData = wordReg;
  assign dispWr    = stb.rdDone;
  assign dispData  = memRdData;

  // R7
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdDone && rdPtr == ADDR_W'(FRAME_WORDS - 1)) |=> rdPtr == '0);

  // R5
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameDone) |-> frameDone);

  // R5
  frame_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> $past(stb.wrDone));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.wrDone == 1'b0) && (stb.rdDone == 1'b0) && !stb.pop && $past(stb.pop) == 1'b0
      && $past(stb.wrDone) == 1'b0 && $past(stb.rdDone) == 1'b0 && stb.rdSel == $past(stb.rdSel)
      && !stb.rdSel) |-> $stable(memWrData));

endmodule

// File: rtl/fieldWeaver.sv
module fieldWeaver
  import fw_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int LINE_WORDS      = 8,
  parameter int LINES_PER_FIELD = 4,
  parameter int ADDR_W          = $clog2(2 * LINES_PER_FIELD * LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capEmpty,
  input  logic [DATA_W-1:0] capData,
  input  logic              capSol,
  input  logic              capField,
  output logic              capRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWr,
  output logic              memRd,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              dispAlmostFull,
  output logic              dispWr,
  output logic [DATA_W-1:0] dispData,
  output logic              frameDone
);

  fwStrobe_t stb;

  weaverCtl i_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .capEmpty       (capEmpty),
    .dispAlmostFull (dispAlmostFull),
    .frameDone      (frameDone),
    .memDone        (memDone),
    .capRd          (capRd),
    .memWr          (memWr),
    .memRd          (memRd),
    .stb            (stb)
  );

  weaverDp #(
    .DATA_W          (DATA_W),
    .LINE_WORDS      (LINE_WORDS),
    .LINES_PER_FIELD (LINES_PER_FIELD),
    .ADDR_W          (ADDR_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .capData   (capData),
    .capSol    (capSol),
    .capField  (capField),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .dispWr    (dispWr),
    .dispData  (dispData),
    .frameDone (frameDone)
  );

  // R8
  disp_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispWr |-> memRd && memDone);

endmodule

// File: tb/test_fieldWeaver.sv
module test_fieldWeaver;

  localparam int DW = 16, LW = 8, LPF = 4, FW = 2 * LPF * LW, AW = $clog2(FW);

  logic          clk = 1'b0, rstN = 1'b0;
  logic          capSolQ [0:255];
  logic          capFieldQ [0:255];
  logic [DW-1:0] capDataQ [0:255];
  int            wrCnt = 0, rdIdx = 0;
  logic          capEmpty, capSol, capField, capRd;
  logic [DW-1:0] capData, memWrData, memRdData = '0, dispData;
  logic [AW-1:0] memAddr;
  logic          memWr, memRd, memDone = 1'b0, dispAlmostFull = 1'b1, dispWr, frameDone;

  logic [DW-1:0] mem [0:FW-1];
  logic [DW-1:0] rdLog [0:127];
  int            rdLogN = 0, writesSeen = 0, readsSeen = 0, reqNum = 0, lat = 0, waitCnt = 0;
  int            firstKind = 0;   // 0 none, 1 write, 2 read
  logic          armFirst = 1'b0;
  int            errs = 0, checks = 0;
  logic          finished = 1'b0;

  assign capEmpty = (rdIdx >= wrCnt);
  assign capData  = capDataQ[rdIdx[7:0]];
  assign capSol   = capSolQ[rdIdx[7:0]];
  assign capField = capFieldQ[rdIdx[7:0]];

  always #5 clk = ~clk;

  fieldWeaver #(.DATA_W(DW), .LINE_WORDS(LW), .LINES_PER_FIELD(LPF)) i_fieldWeaver (
    .clk(clk), .rstN(rstN), .capEmpty(capEmpty), .capData(capData), .capSol(capSol),
    .capField(capField), .capRd(capRd), .memAddr(memAddr), .memWrData(memWrData),
    .memWr(memWr), .memRd(memRd), .memDone(memDone), .memRdData(memRdData),
    .dispAlmostFull(dispAlmostFull), .dispWr(dispWr), .dispData(dispData), .frameDone(frameDone)
  );

  function automatic logic [DW-1:0] pix(int f, int l, int c);
    return DW'(16'h1000 + f * 256 + l * 16 + c);
  endfunction

  function automatic logic [DW-1:0] expAt(int a);
    int row = a / LW;
    return pix(row % 2, row / 2, a % LW);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushField(int f);
    for (int l = 0; l < LPF; l++)
      for (int c = 0; c < LW; c++) begin
        capDataQ[wrCnt]  = pix(f, l, c);
        capSolQ[wrCnt]   = (c == 0);
        capFieldQ[wrCnt] = f[0];
        wrCnt++;
      end
  endtask

  // capture FIFO pop model
  initial begin
    forever begin
      logic p;
      @(negedge clk); p = capRd;
      @(posedge clk); #1;
      if (p) rdIdx++;
    end
  end

  // memory model with 0..2 cycle latency, and display FIFO capture
  initial begin
    for (int i = 0; i < FW; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (memDone) begin
        memDone = 1'b0;
        waitCnt = 0;
      end else if (memWr || memRd) begin
        if (armFirst && firstKind == 0) firstKind = memWr ? 1 : 2;
        if (waitCnt == lat) begin
          memDone = 1'b1;
          if (memWr) begin mem[memAddr] = memWrData; writesSeen++; end
          else begin memRdData = mem[memAddr]; readsSeen++; end
          reqNum++;
          lat = reqNum % 3;
          waitCnt = 0;
        end else waitCnt++;
      end
      #3;
      if (dispWr && rdLogN < 128) begin rdLog[rdLogN] = dispData; rdLogN++; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs quiet during reset
    check("R1 capRd in reset", capRd, 0);
    check("R1 memWr in reset", memWr, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 memRd after reset", memRd, 0);
    check("R1 dispWr after reset", dispWr, 0);
    check("R1 frameDone after reset", frameDone, 0);

    // first field only
    @(negedge clk); pushField(0);
    repeat (400) @(posedge clk); #2;
    check("R5 frameDone low after one field", frameDone, 0);
    check("R2 one write per word (field 0)", writesSeen, LPF * LW);
    check("R6 no read before frame", readsSeen, 0);

    // second field
    @(negedge clk); pushField(1);
    repeat (400) @(posedge clk); #2;
    check("R5 frameDone after second field", frameDone, 1);
    check("R2 one write per word (frame)", writesSeen, FW);
    check("R2 FIFO drained", rdIdx, wrCnt);
    for (int a = 0; a < FW; a++)
      check($sformatf("R3 woven word at %0d", a), mem[a], expAt(a));

    // almost-full blocks reads
    repeat (60) @(posedge clk); #2;
    check("R6 no read while almost full", readsSeen, 0);

    // R9: write and read eligible together
    @(negedge clk);
    capDataQ[wrCnt] = 16'h5A5A; capSolQ[wrCnt] = 1'b1; capFieldQ[wrCnt] = 1'b0; wrCnt++;
    armFirst = 1'b1;
    dispAlmostFull = 1'b0;
    for (int i = 0; i < 2000 && rdLogN < 72; i++) @(posedge clk);
    @(negedge clk); dispAlmostFull = 1'b1;
    check("R9 first request is write", firstKind, 1);
    check("R9 new word stored at row 0", mem[0], 16'h5A5A);
    check("R5 frameDone sticky", frameDone, 1);
    check("R8 read words delivered", (rdLogN >= 72), 1);
    for (int i = 0; i < 72; i++)
      check($sformatf("R7 R8 display word %0d", i), rdLog[i],
            ((i % FW) == 0) ? 16'h5A5A : expAt(i % FW));

    repeat (20) @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule